// File: doc/BRIEF.md
# Multi-output audio clock divider

The block divides one audio master clock into three derived clocks: a bit clock for a digital audio transmitter (128 times the sample rate), a bit clock for a serial DAC (64 times the sample rate) and an oversampling master clock for that DAC. A 4-bit select code chooses all three integer divide ratios at once. Codes 0 to 4 scale a master clock at 768, 512, 384 or 256 times Fs down to fixed output rates. Codes 5 and 6 derive 96 kHz DAC clocks from a 48 kHz family master. Codes 12 to 15 derive 32 kHz family clocks from a 48 kHz family master, using odd ratios where needed.

All three outputs come from counters that restart together at a common frame boundary. The frame length is the largest of the three divisors, and the other two divisors divide it evenly. A new select code is taken only at that boundary, so a switch never cuts a pulse short. Odd ratios reach a duty cycle of one half by stretching each high phase through a falling-edge stage. A ratio of 1 passes the master clock through a gate that opens only while the clock is low.

Top module: `audio_clk_divider`

## Requirements
- R1: While reset is high (synchronous, active high), all three clock outputs are low and the fault flag is low from the second reset edge onward.
- R2: Divisors as (transmitter bit clock, DAC bit clock, DAC master clock): code 0 gives (6,12,3), 1 gives (6,12,2), 2 gives (4,8,2), 3 gives (3,6,1), 4 gives (2,4,1), 5 gives (6,6,1), 6 gives (4,4,1), 12 gives (9,18,3), 13 gives (6,12,3), 14 gives (6,12,2) and 15 gives (3,6,1).
- R3: An output with an even divisor d is low for d/2 master cycles, then high for d/2 cycles, and each period starts with the low part.
- R4: An output with an odd divisor d=2k+1 is low for k cycles plus a half cycle and high for k cycles plus a half cycle. The high part starts on a rising edge and ends on a falling edge.
- R5: An output with divisor 1 follows the master clock. The gate opens and closes only on falling edges, so no partial pulse appears.
- R6: Codes 7 to 11 are unused. Once such a code is applied, all outputs stay low and the fault flag goes high. The flag then stays high until reset, even after a valid code returns.
- R7: A change of the select code takes effect only at the end of the current frame, which is as long as the largest divisor of the active code. Before that, all outputs keep their old pattern.
- R8: At every frame start all three counters are zero together, so all three outputs begin the frame low and keep a fixed phase relation to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_in | input | 1 | Audio master clock; all state is clocked by it |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 4 | Divider select code |
| tx_bit_clk | output | 1 | Transmitter bit clock, 128 x Fs |
| dac_bit_clk | output | 1 | DAC serial bit clock, 64 x Fs |
| dac_over_clk | output | 1 | DAC oversampling master clock |
| sel_fault | output | 1 | Sticky flag set when an unused code is applied |

## Verification
The sensitive coincidence is a code switch at a frame boundary while an odd-ratio output is still in the half cycle stretched by its falling-edge stage, or while the pass-through gate is open. The bench provokes it by holding each code for cycle counts that are not multiples of the frame length. It also chains odd, even and ratio-1 codes in sequence (15, 12, 4, and 3 to 15). A reference model predicts every output in both the high and the low half of each master cycle. A shortened or extra pulse at the switch then shows up as a mismatch in one specific half cycle.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int DIV_W = 5;
    localparam int SEL_W = 4;
    localparam int N_OUT = 3;

    localparam int OUT_TX   = 0;
    localparam int OUT_BCLK = 1;
    localparam int OUT_OVR  = 2;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic                  valid;
        div_t                  frame;
        div_t [N_OUT-1:0]      div;
    } ratio_t;

    localparam ratio_t RATIO_IDLE = '{valid: 1'b0, frame: div_t'(1),
                                      div: {N_OUT{div_t'(1)}}};

    function automatic div_t max3(div_t a, div_t b, div_t c);
        div_t m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic ratio_t mk_ratio(int tx, int bk, int ov);
        ratio_t r;
        r.valid          = 1'b1;
        r.div[OUT_TX]    = div_t'(tx);
        r.div[OUT_BCLK]  = div_t'(bk);
        r.div[OUT_OVR]   = div_t'(ov);
        r.frame          = max3(r.div[OUT_TX], r.div[OUT_BCLK], r.div[OUT_OVR]);
        return r;
    endfunction

    function automatic ratio_t decode_sel(sel_t code);
        case (code)
            4'h0:    return mk_ratio(6, 12, 3);
            4'h1:    return mk_ratio(6, 12, 2);
            4'h2:    return mk_ratio(4, 8, 2);
            4'h3:    return mk_ratio(3, 6, 1);
            4'h4:    return mk_ratio(2, 4, 1);
            4'h5:    return mk_ratio(6, 6, 1);
            4'h6:    return mk_ratio(4, 4, 1);
            4'hC:    return mk_ratio(9, 18, 3);
            4'hD:    return mk_ratio(6, 12, 3);
            4'hE:    return mk_ratio(6, 12, 2);
            4'hF:    return mk_ratio(3, 6, 1);
            default: return RATIO_IDLE;
        endcase
    endfunction

    // First count value of the high part: ceil(d/2)
    function automatic div_t high_start(div_t d);
        logic [DIV_W:0] t;
        t = {1'b0, d} + 1'b1;
        return t[DIV_W:1];
    endfunction

endpackage

// File: rtl/acd_frame_ctrl.sv
module acd_frame_ctrl
    import acd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sel_t   sel,
    output ratio_t cur,
    output ratio_t nxt,
    output logic   wrap,
    output logic   fault
);

    div_t phase;

    always_comb begin
        wrap = (phase == cur.frame - div_t'(1));
        nxt  = wrap ? decode_sel(sel) : cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= RATIO_IDLE;
            phase <= '0;
            fault <= 1'b0;
        end else begin
            cur   <= nxt;
            phase <= wrap ? '0 : phase + div_t'(1);
            if (wrap && !nxt.valid)
                fault <= 1'b1;
        end
    end

endmodule

// File: rtl/acd_clk_gen.sv
module acd_clk_gen
    import acd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  div_t cur_d,
    input  logic cur_on,
    input  div_t nxt_d,
    input  logic nxt_on,
    output logic clk_o,
    output div_t cnt_o,
    output logic pos_o
);

    div_t cnt, cnt_n;
    logic hi_n;
    logic pos_q;
    logic neg_q, odd_l, thru_l;

    always_comb begin
        if (wrap || cnt == cur_d - div_t'(1))
            cnt_n = '0;
        else
            cnt_n = cnt + div_t'(1);
        hi_n = nxt_on && (cnt_n >= high_start(nxt_d));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pos_q <= 1'b0;
        end else begin
            cnt   <= cnt_n;
            pos_q <= hi_n;
        end
    end

    // Falling-edge stage: half-cycle stretch for odd ratios, gate for ratio 1
    always_ff @(negedge clk) begin
        if (rst) begin
            neg_q  <= 1'b0;
            odd_l  <= 1'b0;
            thru_l <= 1'b0;
        end else begin
            neg_q  <= pos_q;
            odd_l  <= cur_on && cur_d[0] && (cur_d != div_t'(1));
            thru_l <= cur_on && (cur_d == div_t'(1));
        end
    end

    assign clk_o = thru_l ? clk : (pos_q | (odd_l & neg_q));
    assign cnt_o = cnt;
    assign pos_o = pos_q;

endmodule

// File: rtl/audio_clk_divider.sv
module audio_clk_divider
    import acd_pkg::*;
(
    input  logic             mclk_in,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             tx_bit_clk,
    output logic             dac_bit_clk,
    output logic             dac_over_clk,
    output logic             sel_fault
);

    ratio_t                      cur, nxt;
    logic                        wrap;
    logic [N_OUT-1:0]            clk_out;
    logic [N_OUT-1:0]            pos_all;
    logic [N_OUT-1:0][DIV_W-1:0] cnt_all;

    acd_frame_ctrl u_frame (
        .clk   (mclk_in),
        .rst   (rst),
        .sel   (ratio_sel),
        .cur   (cur),
        .nxt   (nxt),
        .wrap  (wrap),
        .fault (sel_fault)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        acd_clk_gen u_gen (
            .clk    (mclk_in),
            .rst    (rst),
            .wrap   (wrap),
            .cur_d  (cur.div[g]),
            .cur_on (cur.valid),
            .nxt_d  (nxt.div[g]),
            .nxt_on (nxt.valid),
            .clk_o  (clk_out[g]),
            .cnt_o  (cnt_all[g]),
            .pos_o  (pos_all[g])
        );
    end

    assign tx_bit_clk   = clk_out[OUT_TX];
    assign dac_bit_clk  = clk_out[OUT_BCLK];
    assign dac_over_clk = clk_out[OUT_OVR];

endmodule

// File: rtl/acd_checker.sv
module acd_checker
    import acd_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input sel_t                        sel,
    input logic                        wrap,
    input ratio_t                      cur,
    input logic [N_OUT-1:0]            pos_all,
    input logic [N_OUT-1:0][DIV_W-1:0] cnt_all,
    input logic                        fault
);

    // R1: reset drives the rising-edge stages and the flag low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (pos_all == '0) && !fault);

    // R6: flag is sticky until reset
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R6: an unused code silences every output stage
    p_bad_code_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (wrap && !decode_sel(sel).valid) |=> (pos_all == '0) && fault);

    // R7: the active ratio set changes only at a frame end
    p_switch_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cur));

    // R8: all counters restart together
    p_aligned_restart_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_all == '0));

    // R2: each counter stays inside its divisor
    for (genvar g = 0; g < N_OUT; g++) begin : g_rng
        p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
            cur.valid |-> (cnt_all[g] < cur.div[g]));
    end

endmodule

bind audio_clk_divider acd_checker u_chk (
    .clk     (mclk_in),
    .rst     (rst),
    .sel     (ratio_sel),
    .wrap    (wrap),
    .cur     (cur),
    .pos_all (pos_all),
    .cnt_all (cnt_all),
    .fault   (sel_fault)
);

// File: tb/audio_clk_divider_test.sv
module audio_clk_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sel = 4'h0;
    logic       tx_bit_clk, dac_bit_clk, dac_over_clk, sel_fault;
    logic [2:0] outs;

    always #10 clk = ~clk;   // 50 MHz

    audio_clk_divider uut (
        .mclk_in      (clk),
        .rst          (rst),
        .ratio_sel    (sel),
        .tx_bit_clk   (tx_bit_clk),
        .dac_bit_clk  (dac_bit_clk),
        .dac_over_clk (dac_over_clk),
        .sel_fault    (sel_fault)
    );

    assign outs = {dac_over_clk, dac_bit_clk, tx_bit_clk};

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        logic       f;
        bit         chk;
        string      base;
        string      shape [3];
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // R2 divisor table, index = code, 0 = unused
    int tab_tx [16] = '{6, 6, 4, 3, 2, 6, 4, 0, 0, 0, 0, 0, 9, 6, 6, 3};
    int tab_bk [16] = '{12, 12, 8, 6, 4, 6, 4, 0, 0, 0, 0, 0, 18, 12, 12, 6};
    int tab_ov [16] = '{3, 2, 2, 1, 1, 1, 1, 0, 0, 0, 0, 0, 3, 3, 2, 1};

    // reference state
    int         m_d [3] = '{1, 1, 1};
    bit         m_valid = 1'b0;
    int         m_frame = 1;
    int         m_ph = 0;
    int         m_code = -1;
    logic       m_fault = 1'b0;
    logic [2:0] pos_prev = '0;
    int         rcnt = 0;

    task automatic predict();
        exp_t e;
        int   old_d [3];
        bit   old_valid;
        bit   wrapped;
        logic [2:0] pos;
        old_d     = m_d;
        old_valid = m_valid;
        wrapped   = 1'b0;
        e.base    = "R1";
        for (int k = 0; k < 3; k++) e.shape[k] = "R1";
        if (rst) begin
            rcnt++;
            m_valid  = 1'b0;
            m_d      = '{1, 1, 1};
            m_frame  = 1;
            m_ph     = 0;
            m_code   = -1;
            m_fault  = 1'b0;
            pos_prev = '0;
            e.hi  = '0;
            e.lo  = '0;
            e.f   = 1'b0;
            e.chk = (rcnt >= 2);
        end else begin
            if (m_ph == m_frame - 1) begin
                wrapped = (int'(sel) != m_code);
                m_code  = int'(sel);
                m_valid = (tab_tx[sel] != 0);
                m_ph    = 0;
                if (m_valid) begin
                    m_d[0]  = tab_tx[sel];
                    m_d[1]  = tab_bk[sel];
                    m_d[2]  = tab_ov[sel];
                    m_frame = m_d[1] > m_d[0] ? m_d[1] : m_d[0];
                    if (m_d[2] > m_frame) m_frame = m_d[2];
                end else begin
                    m_d     = '{1, 1, 1};
                    m_frame = 1;
                    m_fault = 1'b1;
                end
            end else begin
                m_ph++;
            end
            for (int k = 0; k < 3; k++) begin
                bit thru_p, odd_p;
                pos[k] = m_valid && ((m_ph % m_d[k]) >= (m_d[k] + 1) / 2);
                thru_p = old_valid && old_d[k] == 1;
                odd_p  = old_valid && (old_d[k] % 2 == 1) && old_d[k] != 1;
                e.hi[k] = thru_p ? 1'b1 : (pos[k] | (odd_p & pos_prev[k]));
                e.lo[k] = pos[k];
                e.shape[k] = (m_d[k] == 1) ? "R5" : ((m_d[k] % 2 == 1) ? "R4" : "R3");
            end
            pos_prev = pos;
            e.f   = m_fault;
            e.chk = 1'b1;
            if (!m_valid)                   e.base = "R6";
            else if (int'(sel) != m_code)   e.base = "R7";
            else if (wrapped)               e.base = "R8";
            else                            e.base = "R2";
        end
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        predict();
    end

    task automatic compare(exp_t e, logic [2:0] want, string ph);
        for (int k = 0; k < 3; k++) begin
            n_cmp++;
            if (outs[k] !== want[k]) begin
                n_bad++;
                $display("FAIL %s/%s out%0d %s-phase t=%0t actual=%b expected=%b",
                         e.base, e.shape[k], k, ph, $time, outs[k], want[k]);
            end
        end
        n_cmp++;
        if (sel_fault !== e.f) begin
            n_bad++;
            $display("FAIL %s fault flag %s-phase t=%0t actual=%b expected=%b",
                     rst ? "R1" : "R6", ph, $time, sel_fault, e.f);
        end
    endtask

    // monitor: one scoreboard item per master cycle, judged in both halves
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R1 scoreboard empty actual=0 expected=1");
            end else begin
                e = q.pop_front();
                if (e.chk) compare(e, e.hi, "high");
                #10;
                if (e.chk) compare(e, e.lo, "low");
            end
        end
    end

    task automatic hold(int code, int n);
        sel = 4'(code);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5) @(posedge clk);   // R1 reset window
        #4;
        rst = 1'b0;
        // R2..R5: every valid code, hold lengths off the frame grid (R7)
        hold(4'h0, 40);
        hold(4'h1, 37);
        hold(4'h2, 41);
        hold(4'h3, 29);
        hold(4'h4, 33);
        hold(4'h5, 44);
        hold(4'h6, 31);
        hold(4'hC, 55);
        hold(4'hD, 47);
        hold(4'hE, 38);
        hold(4'hF, 27);
        // R4/R5/R8: odd and pass-through chains across boundaries
        hold(4'h3, 20);
        hold(4'hF, 20);
        hold(4'hC, 40);
        hold(4'h4, 30);
        hold(4'hC, 7);    // R7: withdrawn before the frame ends
        hold(4'h4, 25);
        // R6: unused code, then recovery with flag still set
        hold(4'h9, 20);
        hold(4'h2, 30);
        // R1: reset clears the flag
        rst = 1'b1;
        hold(4'h2, 4);
        rst = 1'b0;
        hold(4'hB, 10);
        hold(4'hE, 40);
        hold(4'h7, 5);
        hold(4'h0, 30);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule